// File: doc/BRIEF.md
# Flag-Setting ALU with Insert Operations

This block is the combinational arithmetic and logic unit of a 32-bit integer core. It takes an operation code, two operands, the current carry flag and a single condition/insert bit that a separate condition unit supplies. It returns a 32-bit result, new values for the zero, sign, overflow and carry flags, and a four-bit write mask. The mask says which flags the caller should update; flags whose mask bit is clear keep their old value outside the block.

The operation set covers four arithmetic operations: add, subtract, add with carry and subtract with borrow. It has two one-position shifts that fill the vacated end with the supplied bit. Every one-bit shift and rotate is built from these two shifts by choosing the bit the caller feeds in. It has three logic operations, each with a variant that inverts the second operand first. It also has two operations that place a 16-bit immediate under a shifted copy of the second operand, either plain or inverted. An immediate subtract is a plain subtract with the sign-extended immediate already on operand A.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives opA+opB and opcode 2 (add with carry) gives opA+opB+carryIn. CF is the unsigned carry out of bit 31. OF is set on signed overflow. flagWe is 4'b1111.
- R2: Opcode 1 (subtract) gives opA-opB and opcode 3 (subtract with borrow) gives opA-opB-carryIn. CF is set when an unsigned borrow occurs. OF is set on signed overflow. flagWe is 4'b1111. A subtract with a sign-extended immediate on opA computes immediate minus opB.
- R3: Opcode 4 (insert low) gives {opA[30:0], insBit}. CF is opA[31], OF is result[31] XOR opA[31], and flagWe is 4'b1111.
- R4: Opcode 5 (insert high) gives {insBit, opA[31:1]}. CF is opA[0], OF is result[31] XOR opA[31], and flagWe is 4'b1111.
- R5: The logic opcodes are 6 (A&B), 7 (A&~B), 8 (A^B), 9 (A^~B), 10 (A|B) and 11 (A|~B). Each writes only ZF and SF, so flagWe is 4'b1100.
- R6: Opcode 12 gives {opB[15:0], opA[15:0]} and opcode 13 gives {~opB[15:0], opA[15:0]}; opA is the zero-extended immediate. Both give flagWe 4'b0000.
- R7: Whenever a flag is written, ZF is 1 exactly when the result is zero and SF equals result[31]. flagWe bit 3 is ZF, bit 2 is SF, bit 1 is OF and bit 0 is CF.
- R8: A flag output whose flagWe bit is clear reads 0. Opcodes 14 and 15 give result 0 and flagWe 4'b0000.
- R9: carryIn has no effect on opcodes 0, 1 and 4 to 13, and insBit has no effect on any opcode other than 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand (immediate for immediate forms) |
| opB | input | 32 | Second operand |
| carryIn | input | 1 | Current carry flag |
| insBit | input | 1 | Bit inserted by the shift operations |
| result | output | 32 | Operation result |
| zfOut | output | 1 | New zero flag |
| sfOut | output | 1 | New sign flag |
| ofOut | output | 1 | New overflow flag |
| cfOut | output | 1 | New carry flag |
| flagWe | output | 4 | Flag write mask {Z,S,O,C} |

## Verification
The block holds no state, so a wrong decode or a misrouted carry shows at the ports in the same evaluation as the stimulus. A corrupted strobe struct shows in one of three ways. It can give the wrong write mask, which the logic and immediate-insert checks catch. It can give a wrong carry polarity, which borrow cases with both carryIn values expose. It can place the inserted bit at the wrong end, which the insert and rotate idioms reveal. Overflow and borrow boundaries are driven at 0x7FFFFFFF, 0x80000000 and all-ones.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADC   = 4'd2,
    OP_SBB   = 4'd3,
    OP_INSLO = 4'd4,
    OP_INSHI = 4'd5,
    OP_AND   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_XOR   = 4'd8,
    OP_XORN  = 4'd9,
    OP_OR    = 4'd10,
    OP_ORN   = 4'd11,
    OP_IMM   = 4'd12,
    OP_IMMN  = 4'd13
  } alu_op_e;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_SUM,
    RS_INSLO,
    RS_INSHI,
    RS_AND,
    RS_XOR,
    RS_OR,
    RS_IMM
  } res_sel_e;

  // Mask bit positions inside the flag write mask.
  localparam int FLAG_Z = 3;
  localparam int FLAG_S = 2;
  localparam int FLAG_O = 1;
  localparam int FLAG_C = 0;

  typedef struct packed {
    res_sel_e   resSel;
    logic       invB;      // invert operand B before use
    logic       subMode;   // arithmetic is a subtraction
    logic       useCarry;  // fold carryIn into the sum
    logic [3:0] flagWe;    // {Z,S,O,C}
  } alu_strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output alu_strobe_t strobe
);

  always_comb begin
    strobe = '{resSel: RS_ZERO, invB: 1'b0, subMode: 1'b0,
               useCarry: 1'b0, flagWe: 4'b0000};
    unique case (opSel)
      OP_ADD:   begin strobe.resSel = RS_SUM; strobe.flagWe = 4'b1111; end
      OP_ADC:   begin strobe.resSel = RS_SUM; strobe.useCarry = 1'b1;
                      strobe.flagWe = 4'b1111; end
      OP_SUB:   begin strobe.resSel = RS_SUM; strobe.invB = 1'b1;
                      strobe.subMode = 1'b1; strobe.flagWe = 4'b1111; end
      OP_SBB:   begin strobe.resSel = RS_SUM; strobe.invB = 1'b1;
                      strobe.subMode = 1'b1; strobe.useCarry = 1'b1;
                      strobe.flagWe = 4'b1111; end
      OP_INSLO: begin strobe.resSel = RS_INSLO; strobe.flagWe = 4'b1111; end
      OP_INSHI: begin strobe.resSel = RS_INSHI; strobe.flagWe = 4'b1111; end
      OP_AND:   begin strobe.resSel = RS_AND; strobe.flagWe = 4'b1100; end
      OP_ANDN:  begin strobe.resSel = RS_AND; strobe.invB = 1'b1;
                      strobe.flagWe = 4'b1100; end
      OP_XOR:   begin strobe.resSel = RS_XOR; strobe.flagWe = 4'b1100; end
      OP_XORN:  begin strobe.resSel = RS_XOR; strobe.invB = 1'b1;
                      strobe.flagWe = 4'b1100; end
      OP_OR:    begin strobe.resSel = RS_OR; strobe.flagWe = 4'b1100; end
      OP_ORN:   begin strobe.resSel = RS_OR; strobe.invB = 1'b1;
                      strobe.flagWe = 4'b1100; end
      OP_IMM:   strobe.resSel = RS_IMM;
      OP_IMMN:  begin strobe.resSel = RS_IMM; strobe.invB = 1'b1; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  alu_strobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             insBit,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);

  localparam int MSB = WIDTH - 1;
  localparam int HI_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] bEff;
  logic             cinEff;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             arithCf, arithOf;
  logic [3:0]       rawFlags;
  logic             shiftCf;

  assign bEff   = strobe.invB ? ~opB : opB;
  assign cinEff = strobe.subMode ? ~(strobe.useCarry & carryIn)
                                 : (strobe.useCarry & carryIn);
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, cinEff};
  assign sum     = sumWide[WIDTH-1:0];
  // Carry out inverted is the borrow for a subtraction.
  assign arithCf = strobe.subMode ? ~sumWide[WIDTH] : sumWide[WIDTH];
  assign arithOf = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);

  always_comb begin
    unique case (strobe.resSel)
      RS_SUM:   result = sum;
      RS_INSLO: result = {opA[MSB-1:0], insBit};
      RS_INSHI: result = {insBit, opA[MSB:1]};
      RS_AND:   result = opA & bEff;
      RS_XOR:   result = opA ^ bEff;
      RS_OR:    result = opA | bEff;
      RS_IMM:   result = {bEff[HI_W-1:0], opA[IMM_W-1:0]};
      default:  result = '0;
    endcase
  end

  assign shiftCf = (strobe.resSel == RS_INSLO) ? opA[MSB] : opA[0];

  always_comb begin
    rawFlags[FLAG_Z] = (result == '0);
    rawFlags[FLAG_S] = result[MSB];
    if (strobe.resSel == RS_SUM) begin
      rawFlags[FLAG_O] = arithOf;
      rawFlags[FLAG_C] = arithCf;
    end else begin
      rawFlags[FLAG_O] = result[MSB] ^ opA[MSB];
      rawFlags[FLAG_C] = shiftCf;
    end
  end

  assign flags = rawFlags & strobe.flagWe;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             insBit,
  output logic [WIDTH-1:0] result,
  output logic             zfOut,
  output logic             sfOut,
  output logic             ofOut,
  output logic             cfOut,
  output logic [3:0]       flagWe
);

  alu_strobe_t strobe;
  logic [3:0]  flags;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_dpath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dpath (
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .insBit  (insBit),
    .result  (result),
    .flags   (flags)
  );

  assign zfOut  = flags[FLAG_Z];
  assign sfOut  = flags[FLAG_S];
  assign ofOut  = flags[FLAG_O];
  assign cfOut  = flags[FLAG_C];
  assign flagWe = strobe.flagWe;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] opA,
  input logic             insBit,
  input logic [WIDTH-1:0] result,
  input logic             zfOut,
  input logic             sfOut,
  input logic             ofOut,
  input logic             cfOut,
  input logic [3:0]       flagWe
);

  always_comb begin
    if (opSel == 4'd4) begin
      // R3: inserted bit lands at the low end, old MSB goes to carry
      assert_ins_low_R3: assert (result[0] == insBit && cfOut == opA[WIDTH-1]);
    end
    if (opSel == 4'd5) begin
      // R4: inserted bit lands at the high end, old LSB goes to carry
      assert_ins_high_R4: assert (result[WIDTH-1] == insBit && cfOut == opA[0]);
    end
    if (opSel >= 4'd6 && opSel <= 4'd11) begin
      assert_logic_mask_R5: assert (flagWe == 4'b1100 && !ofOut && !cfOut);
    end
    if (opSel == 4'd12 || opSel == 4'd13) begin
      assert_imm_noflags_R6: assert (flagWe == 4'b0000);
    end
    if (flagWe[3]) begin
      assert_zero_flag_R7: assert (zfOut == (result == '0));
    end
    if (flagWe[2]) begin
      assert_sign_flag_R7: assert (sfOut == result[WIDTH-1]);
    end
    assert_masked_zero_R8: assert (({zfOut, sfOut, ofOut, cfOut} & ~flagWe) == 4'b0000);
  end

endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opSel  (opSel),
  .opA    (opA),
  .insBit (insBit),
  .result (result),
  .zfOut  (zfOut),
  .sfOut  (sfOut),
  .ofOut  (ofOut),
  .cfOut  (cfOut),
  .flagWe (flagWe)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0, insBit = 1'b0;
  logic [31:0] result;
  logic        zfOut, sfOut, ofOut, cfOut;
  logic [3:0]  flagWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flag_alu dut (
    .opSel(opSel), .opA(opA), .opB(opB), .carryIn(carryIn), .insBit(insBit),
    .result(result), .zfOut(zfOut), .sfOut(sfOut), .ofOut(ofOut),
    .cfOut(cfOut), .flagWe(flagWe)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic        ins;
    logic [31:0] res;
    logic [3:0]  flg;  // {Z,S,O,C}
    logic [3:0]  we;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{4'd0, 32'h7FFFFFFF, 32'h1, 1'b1, 1'b1, 32'h80000000, 4'b0110, 4'hF, 4'd1}, // R1 overflow, cin ignored (R9)
    '{4'd0, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 32'h0,        4'b1001, 4'hF, 4'd1}, // R1 carry out
    '{4'd1, 32'h5,        32'h7, 1'b1, 1'b0, 32'hFFFFFFFE, 4'b0101, 4'hF, 4'd2}, // R2 borrow
    '{4'd1, 32'h80000000, 32'h1, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'hF, 4'd2}, // R2 overflow
    '{4'd2, 32'h10,       32'h20, 1'b1, 1'b0, 32'h31,      4'b0000, 4'hF, 4'd1}, // R1 adc
    '{4'd3, 32'h10,       32'h10, 1'b1, 1'b0, 32'hFFFFFFFF,4'b0101, 4'hF, 4'd2}, // R2 sbb borrow
    '{4'd3, 32'h5,        32'h3, 1'b0, 1'b0, 32'h2,        4'b0000, 4'hF, 4'd2}, // R2 sbb no borrow
    '{4'd4, 32'hC0000001, 32'h0, 1'b1, 1'b1, 32'h80000003, 4'b0101, 4'hF, 4'd3}, // R3
    '{4'd4, 32'h40000000, 32'h0, 1'b0, 1'b0, 32'h80000000, 4'b0110, 4'hF, 4'd3}, // R3 of
    '{4'd5, 32'h00000003, 32'h0, 1'b0, 1'b1, 32'h80000001, 4'b0111, 4'hF, 4'd4}, // R4
    '{4'd5, 32'h00000001, 32'h0, 1'b1, 1'b0, 32'h0,        4'b1001, 4'hF, 4'd4}, // R4 zero
    '{4'd6, 32'h0000F0F0, 32'h00000FF0, 1'b1, 1'b1, 32'h000000F0, 4'b0000, 4'hC, 4'd5}, // R5 and
    '{4'd7, 32'h000000FF, 32'h000000FF, 1'b0, 1'b0, 32'h0,        4'b1000, 4'hC, 4'd5}, // R5 andn
    '{4'd8, 32'hFFFF0000, 32'h0000FFFF, 1'b0, 1'b0, 32'hFFFFFFFF, 4'b0100, 4'hC, 4'd5}, // R5 xor
    '{4'd9, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 32'hFFFFFFFF, 4'b0100, 4'hC, 4'd5}, // R5 xorn
    '{4'd10, 32'h0,       32'h0,        1'b1, 1'b0, 32'h0,        4'b1000, 4'hC, 4'd5}, // R5 or
    '{4'd11, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1, 32'h80000000, 4'b0100, 4'hC, 4'd5}, // R5 orn
    '{4'd12, 32'hFFFFBEEF, 32'h00001234, 1'b1, 1'b1, 32'h1234BEEF, 4'b0000, 4'h0, 4'd6}, // R6
    '{4'd13, 32'h00001111, 32'h0000FFF0, 1'b0, 1'b0, 32'h000F1111, 4'b0000, 4'h0, 4'd6}, // R6 negated
    '{4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 32'h0,        4'b0000, 4'h0, 4'd8}, // R8 unassigned
    '{4'd1, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 32'hFFFFFFFE, 4'b0100, 4'hF, 4'd2}  // R2 imm(-1) minus 1
  };

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic cin, input logic ins);
    @(posedge clk);
    #2;
    opSel = op; opA = a; opB = b; carryIn = cin; insBit = ins;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] expRes,
                       input logic [3:0] expFlg, input logic [3:0] expWe);
    checks++;
    if (result !== expRes || {zfOut, sfOut, ofOut, cfOut} !== expFlg || flagWe !== expWe) begin
      errors++;
      $display("FAIL %s: got res=%h flg=%b we=%b, expected res=%h flg=%b we=%b",
               tag, result, {zfOut, sfOut, ofOut, cfOut}, flagWe, expRes, expFlg, expWe);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset state: idle inputs are all zero, so ADD of zeros is seen (R7).
    apply(4'd0, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R7 idle add of zeros", 32'h0, 4'b1000, 4'hF);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].cin, VEC[i].ins);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].res, VEC[i].flg, VEC[i].we);
    end

    // R1: add with carry of a value with itself rotates left through carry.
    v = 32'h80000001;
    apply(4'd2, v, v, 1'b1, 1'b0);
    check("R1 rotate-left-through-carry", {v[30:0], 1'b1}, 4'b0011, 4'hF);

    // R3: insert-low with own MSB rotates left.
    v = 32'h80000001;
    apply(4'd4, v, 32'h0, 1'b0, v[31]);
    check("R3 rotate-left idiom", {v[30:0], v[31]}, 4'b0011, 4'hF);

    // R4: insert-high with own MSB is an arithmetic right shift.
    v = 32'h80000004;
    apply(4'd5, v, 32'h0, 1'b0, v[31]);
    check("R4 arithmetic shift right idiom", 32'hC0000002, 4'b0100, 4'hF);

    // R9: carryIn has no effect on plain subtract; compare both values.
    apply(4'd1, 32'h5, 32'h5, 1'b0, 1'b1);
    check("R9 sub cin=0", 32'h0, 4'b1000, 4'hF);
    apply(4'd1, 32'h5, 32'h5, 1'b1, 1'b0);
    check("R9 sub cin=1", 32'h0, 4'b1000, 4'hF);

    // R2: borrow-in propagates to zero without a borrow out.
    apply(4'd3, 32'h1, 32'h0, 1'b1, 1'b0);
    check("R2 sbb 1-0-1", 32'h0, 4'b1000, 4'hF);

    // R8: highest opcode is unassigned.
    apply(4'd15, 32'h1234, 32'h5678, 1'b1, 1'b1);
    check("R8 opcode 15", 32'h0, 4'b0000, 4'h0);

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finishRun();
    end
  end

endmodule